// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 20-bit virtual address into a physical address by walking a two-level table held in memory. A caller hands it a virtual address over a valid/ready request channel. The walker reads one entry from the page directory, which starts at a base address supplied on a plain input. If that entry is usable, the walker reads a second entry from the inner table that the first entry points to. It then returns a result on a valid/ready channel: the frame number, the full physical address and two permission bits, or a status code that gives the reason the walk failed.

Both table reads go through one memory read port. Its request side is valid/ready and can take any number of cycles to accept. The response returns a cycle or more later and is marked by a one-cycle valid pulse. When a walk succeeds, a one-cycle fill strobe carries the virtual page number and the frame number, so that a translation cache can load the pair. Back-pressure rules are as follows. The walker takes a new request only when it is idle. It holds a memory request, address included, until the port accepts it. It holds a result until the consumer raises ready. A memory response that arrives while no read is outstanding is ignored.

Every table entry is a 32-bit word with the following fields: bit 31 valid, bit 30 present, bits 29:28 permission, bits 7:0 frame number. The virtual address fields are: bits 19:16 directory index, bits 15:12 inner index, bits 11:0 byte offset.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of a walk uses the address `pd_base + 4 * va[19:16]`, where `pd_base` is the value sampled when the request is accepted.
- R2: When the directory entry has bit 31 clear, the walk ends with status 1 (bad directory) after exactly one memory read.
- R3: When the directory entry is valid, a second read is issued at `{dir[7:0], 12'h000} + 4 * va[15:12]`, so a walk that gets past the directory makes exactly two reads.
- R4: When the inner entry has bit 31 clear, the walk ends with status 2 (bad entry).
- R5: When the inner entry has bit 31 set and bit 30 clear, the walk ends with status 3 (page absent). This is distinct from status 2.
- R6: When the inner entry is valid and present, the result has status 0, `res_pfn = pte[7:0]`, `res_perm = pte[29:28]` and `res_paddr = {pte[7:0], va[11:0]}`.
- R7: A successful walk raises `fill_valid` for exactly one cycle, in the first cycle the result is offered, with `fill_vpn = va[19:12]` and `fill_pfn = pte[7:0]`. A failed walk raises no fill.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged in the next cycle.
- R9: Only one walk is in flight. `req_ready` is low from acceptance until the result is taken, and a result stays valid and unchanged until `res_ready` is high.
- R10: A failed walk reports zero for `res_pfn`, `res_paddr` and `res_perm`.
- R11: After reset the walker is idle: `req_ready` is high, and `res_valid`, `mem_req_valid` and `fill_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_base | input | 20 | Physical base address of the page directory |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 20 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory port accepts the read |
| mem_req_addr | output | 20 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data returned (one-cycle pulse) |
| mem_rsp_data | input | 32 | Table entry word |
| res_valid | output | 1 | Walk result offered |
| res_ready | input | 1 | Consumer takes the result |
| res_status | output | 2 | 0 ok, 1 bad directory, 2 bad entry, 3 page absent |
| res_pfn | output | 8 | Final frame number |
| res_paddr | output | 20 | Physical address |
| res_perm | output | 2 | Permission bits of the final entry |
| fill_valid | output | 1 | One-cycle translation fill strobe |
| fill_vpn | output | 8 | Virtual page number for the fill |
| fill_pfn | output | 8 | Frame number for the fill |

## Verification
If the walker's state drifts, the first visible sign is usually at the memory port. A read at the wrong address, or a missing second read, shows up one cycle after the request is accepted or after the directory response arrives. Errors in status selection or frame capture appear in the result fields in the first cycle that `res_valid` is high, and a misplaced fill shows up in that same cycle. Losing track of a held request or result makes the address or the result fields change under back-pressure in the very next cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Positions of the fields in a table entry.
  localparam int ENT_VALID_BIT   = 31;
  localparam int ENT_PRESENT_BIT = 30;
  localparam int ENT_PERM_HI     = 29;
  localparam int ENT_PERM_LO     = 28;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_PD,
    ST_WAIT_PD,
    ST_READ_PT,
    ST_WAIT_PT,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    WS_OK      = 2'd0,
    WS_BAD_DIR = 2'd1,
    WS_BAD_PTE = 2'd2,
    WS_ABSENT  = 2'd3
  } walk_status_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W    = 20,
  parameter int OUT_W   = 4,
  parameter int IN_W    = 4,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 8,
  parameter int ENT_LG2 = 2
) (
  input  logic [PA_W-1:0]  dir_base,
  input  logic [OUT_W-1:0] outer_idx,
  input  logic [IN_W-1:0]  inner_idx,
  input  logic [PFN_W-1:0] table_pfn,
  output logic [PA_W-1:0]  dir_addr,
  output logic [PA_W-1:0]  tbl_addr
);
  logic [PA_W-1:0] outer_byte;
  logic [PA_W-1:0] inner_byte;
  logic [PA_W-1:0] table_base;

  // Scale each index by the entry size to get a byte offset.
  assign outer_byte = PA_W'({outer_idx, {ENT_LG2{1'b0}}});
  assign inner_byte = PA_W'({inner_idx, {ENT_LG2{1'b0}}});
  assign table_base = PA_W'({table_pfn, {OFF_W{1'b0}}});

  assign dir_addr = dir_base + outer_byte;
  assign tbl_addr = table_base + inner_byte;
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int ENT_W = 32,
  parameter int PFN_W = 8
) (
  input  logic [ENT_W-1:0] entry,
  output logic             ent_valid,
  output logic             ent_present,
  output logic [1:0]       ent_perm,
  output logic [PFN_W-1:0] ent_pfn
);
  import ptw_pkg::*;

  assign ent_valid   = entry[ENT_VALID_BIT];
  assign ent_present = entry[ENT_PRESENT_BIT];
  assign ent_perm    = entry[ENT_PERM_HI:ENT_PERM_LO];
  assign ent_pfn     = entry[PFN_W-1:0];

  logic unused_bits;
  assign unused_bits = ^entry[ENT_PERM_LO-1:PFN_W];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int OUT_W = 4,
  parameter int IN_W  = 4,
  parameter int OFF_W = 12,
  parameter int PFN_W = 8,
  parameter int ENT_W = 32,
  localparam int VA_W    = OUT_W + IN_W + OFF_W,
  localparam int PA_W    = PFN_W + OFF_W,
  localparam int VPN_W   = OUT_W + IN_W,
  localparam int ENT_LG2 = $clog2(ENT_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  pd_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [1:0]       res_status,
  output logic [PFN_W-1:0] res_pfn,
  output logic [PA_W-1:0]  res_paddr,
  output logic [1:0]       res_perm,
  output logic             fill_valid,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PFN_W-1:0] fill_pfn
);
  import ptw_pkg::*;

  walk_state_e  state_q;
  walk_status_e status_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic [PFN_W-1:0] tbl_q;
  logic [PFN_W-1:0] pfn_q;
  logic [1:0]       perm_q;
  logic             fill_q;

  logic [PA_W-1:0]  dir_addr;
  logic [PA_W-1:0]  tbl_addr;
  logic             ent_valid;
  logic             ent_present;
  logic [1:0]       ent_perm;
  logic [PFN_W-1:0] ent_pfn;

  ptw_addr_gen #(
    .PA_W(PA_W), .OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W),
    .PFN_W(PFN_W), .ENT_LG2(ENT_LG2)
  ) u_addr (
    .dir_base (base_q),
    .outer_idx(va_q[VA_W-1 -: OUT_W]),
    .inner_idx(va_q[OFF_W +: IN_W]),
    .table_pfn(tbl_q),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr)
  );

  ptw_pte_decode #(.ENT_W(ENT_W), .PFN_W(PFN_W)) u_dec (
    .entry      (mem_rsp_data),
    .ent_valid  (ent_valid),
    .ent_present(ent_present),
    .ent_perm   (ent_perm),
    .ent_pfn    (ent_pfn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      status_q <= WS_OK;
      va_q     <= '0;
      base_q   <= '0;
      tbl_q    <= '0;
      pfn_q    <= '0;
      perm_q   <= '0;
      fill_q   <= 1'b0;
    end else begin
      fill_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            base_q   <= pd_base;
            status_q <= WS_OK;
            pfn_q    <= '0;
            perm_q   <= '0;
            state_q  <= ST_READ_PD;
          end
        end
        ST_READ_PD: if (mem_req_ready) state_q <= ST_WAIT_PD;
        ST_WAIT_PD: begin
          if (mem_rsp_valid) begin
            if (!ent_valid) begin
              status_q <= WS_BAD_DIR;
              state_q  <= ST_FAULT;
            end else begin
              tbl_q   <= ent_pfn;
              state_q <= ST_READ_PT;
            end
          end
        end
        ST_READ_PT: if (mem_req_ready) state_q <= ST_WAIT_PT;
        ST_WAIT_PT: begin
          if (mem_rsp_valid) begin
            if (!ent_valid) begin
              status_q <= WS_BAD_PTE;
              state_q  <= ST_FAULT;
            end else if (!ent_present) begin
              status_q <= WS_ABSENT;
              state_q  <= ST_FAULT;
            end else begin
              pfn_q   <= ent_pfn;
              perm_q  <= ent_perm;
              fill_q  <= 1'b1;
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_READ_PD) || (state_q == ST_READ_PT);
  assign mem_req_addr  = (state_q == ST_READ_PT) ? tbl_addr : dir_addr;

  assign res_valid  = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign res_status = status_q;
  assign res_pfn    = pfn_q;
  assign res_perm   = perm_q;
  assign res_paddr  = (state_q == ST_DONE) ? {pfn_q, va_q[OFF_W-1:0]} : '0;

  assign fill_valid = fill_q;
  assign fill_vpn   = va_q[VA_W-1:OFF_W];
  assign fill_pfn   = pfn_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W  = 20,
  parameter int PFN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             res_valid,
  input logic             res_ready,
  input logic [1:0]       res_status,
  input logic [PFN_W-1:0] res_pfn,
  input logic [PA_W-1:0]  res_paddr,
  input logic             fill_valid
);
  // Memory reads accepted since the current walk was taken.
  logic [1:0] rd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_cnt <= '0;
    else if (req_valid && req_ready) rd_cnt <= '0;
    else if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
  end

  assert_entry_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  assert_dir_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'd1) |-> rd_cnt == 2'd1);

  assert_two_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status != 2'd1) |-> rd_cnt == 2'd2);

  assert_fill_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (res_valid && res_status == 2'd0));

  assert_fill_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);

  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_one_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || res_valid) |-> !req_ready);

  assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_status) &&
                                   $stable(res_pfn) && $stable(res_paddr)));
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .PFN_W(PFN_W)) u_chk (.*);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] pd_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vaddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [19:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [1:0]  res_status;
  logic [7:0]  res_pfn;
  logic [19:0] res_paddr;
  logic [1:0]  res_perm;
  logic        fill_valid;
  logic [7:0]  fill_vpn;
  logic [7:0]  fill_pfn;

  always #2.5 clk = ~clk;

  ptw_walker u_ptw_walker (.*);

  typedef struct {
    logic [1:0]  st;
    logic [7:0]  pfn;
    logic [19:0] pa;
    logic [1:0]  perm;
    int          reads;
    logic [7:0]  vpn;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem [logic [19:0]];
  int checks = 0;
  int errors = 0;
  int reads_total = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [19:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] ent(bit v, bit p, logic [1:0] perm, logic [7:0] pfn);
    return {v, p, perm, 20'h0, pfn};
  endfunction

  // Driver: compute the expected outcome, queue it, then offer the request.
  task automatic do_walk(logic [19:0] va);
    exp_t e;
    logic [19:0] da;
    logic [31:0] de, te;
    da = pd_base + {14'h0, va[19:16], 2'b00};
    de = rd(da);
    e.vpn = va[19:12]; e.pfn = '0; e.pa = '0; e.perm = '0;
    if (!de[31]) begin
      e.st = 2'd1; e.reads = 1;
    end else begin
      e.reads = 2;
      te = rd({de[7:0], 12'h000} + {14'h0, va[15:12], 2'b00});
      if (!te[31]) e.st = 2'd2;
      else if (!te[30]) e.st = 2'd3;
      else begin
        e.st = 2'd0; e.pfn = te[7:0]; e.perm = te[29:28]; e.pa = {te[7:0], va[11:0]};
      end
    end
    sb.push_back(e);
    @(posedge clk); #1;
    req_vaddr = va;
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) break;
    end
    chk("R1", "directory read address", {12'h0, mem_req_addr}, {12'h0, da});
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Memory model: variable accept delay and response latency.
  initial begin
    bit pend = 0;
    int lat = 0;
    logic [19:0] pa = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid && mem_req_ready && !pend) begin
        pend = 1; pa = mem_req_addr; lat = $urandom_range(0, 3);
        reads_total++;
      end
      @(posedge clk); #1;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = rd(pa); pend = 0;
        end else lat--;
      end
      mem_req_ready = ($urandom_range(0, 2) != 0);
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      res_ready = ($urandom_range(0, 3) != 0);
    end
  end

  // Monitor: fill tracking, hold checks and scoreboard comparison.
  initial begin
    int fills = 0;
    int last_reads = 0;
    logic [7:0] fvpn = '0, fpfn = '0;
    bit hold = 0;
    logic [19:0] hold_addr = '0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold) begin
          chk("R8", "request held", {31'h0, mem_req_valid}, 32'h1);
          chk("R8", "address held", {12'h0, mem_req_addr}, {12'h0, hold_addr});
        end
        hold = mem_req_valid && !mem_req_ready;
        hold_addr = mem_req_addr;
        if (mem_req_valid || res_valid)
          chk("R9", "req_ready while busy", {31'h0, req_ready}, 32'h0);
        if (fill_valid) begin
          fills++; fvpn = fill_vpn; fpfn = fill_pfn;
        end
        if (res_valid && res_ready) begin
          if (sb.size() == 0) begin
            chk("R9", "unexpected result", 32'h1, 32'h0);
          end else begin
            string t;
            string dt;
            e = sb.pop_front();
            t  = (e.st == 2'd0) ? "R6" : (e.st == 2'd1) ? "R2" : (e.st == 2'd2) ? "R4" : "R5";
            dt = (e.st == 2'd0) ? "R6" : "R10";
            chk(t, "status", {30'h0, res_status}, {30'h0, e.st});
            chk(dt, "pfn", {24'h0, res_pfn}, {24'h0, e.pfn});
            chk(dt, "paddr", {12'h0, res_paddr}, {12'h0, e.pa});
            chk(dt, "perm", {30'h0, res_perm}, {30'h0, e.perm});
            chk((e.reads == 1) ? "R2" : "R3", "read count",
                reads_total - last_reads, e.reads);
            chk("R7", "fill count", fills, (e.st == 2'd0) ? 1 : 0);
            if (e.st == 2'd0) begin
              chk("R7", "fill vpn", {24'h0, fvpn}, {24'h0, e.vpn});
              chk("R7", "fill pfn", {24'h0, fpfn}, {24'h0, e.pfn});
            end
          end
          fills = 0;
          last_reads = reads_total;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Directory at 0x01000: slot 0 -> table 0x03, slot 15 -> table 0x92.
    pd_base = 20'h01000;
    mem[20'h01000] = ent(1, 0, 2'b00, 8'h03);
    mem[20'h0103C] = ent(1, 0, 2'b00, 8'h92);
    mem[20'h03000] = ent(1, 1, 2'b10, 8'h10);
    mem[20'h03004] = ent(1, 1, 2'b11, 8'h23);
    mem[20'h0300C] = ent(1, 0, 2'b01, 8'h80);
    mem[20'h03010] = ent(0, 1, 2'b11, 8'h59);
    mem[20'h03014] = ent(1, 1, 2'b01, 8'h59);
    mem[20'h92038] = ent(1, 1, 2'b11, 8'h55);
    mem[20'h9203C] = ent(1, 1, 2'b00, 8'h45);
    // Second directory at 0x20000: slot 5 -> table 0x03.
    mem[20'h20014] = ent(1, 0, 2'b00, 8'h03);

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: state held in reset and just after release.
    chk("R11", "req_ready in reset", {31'h0, req_ready}, 32'h1);
    chk("R11", "res_valid in reset", {31'h0, res_valid}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "req_ready", {31'h0, req_ready}, 32'h1);
    chk("R11", "res_valid", {31'h0, res_valid}, 32'h0);
    chk("R11", "mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    chk("R11", "fill_valid", {31'h0, fill_valid}, 32'h0);

    do_walk(20'h00ABC);  // R6 success
    do_walk(20'h01123);  // R6 success, other perm
    do_walk(20'h03FFF);  // R5 absent
    do_walk(20'h04000);  // R4 invalid entry
    do_walk(20'h02000);  // R4 never written entry
    do_walk(20'h50000);  // R2 directory invalid
    do_walk(20'hFEED0);  // R6 via second table
    do_walk(20'hFFFFF);  // R6 last slot of both levels
    do_walk(20'h05777);  // R6
    drain();

    pd_base = 20'h20000;  // R1: base is sampled per walk
    do_walk(20'h51234);   // slot 5 -> table 0x03, inner 1
    do_walk(20'h00ABC);   // slot 0 empty in this directory
    drain();

    pd_base = 20'h01000;
    for (int i = 0; i < 16; i++)
      if (i != 0 && i != 15) mem[20'h01000 + i * 4] = ent(i[0], 0, 2'b00, 8'h03);
    for (int i = 0; i < 60; i++) do_walk(20'($urandom));
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule